// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous SRAM

A single-port synchronous static memory whose write path lags its command by one clock. The command, address and byte enables of a write are registered on one rising edge. The write data is taken on the next enabled edge. A read returns its word during the cycle after its command, so the data bus carries one transfer per cycle for any mix of reads and writes, with no idle cycle between them. Captured write data waits in a pending register and goes into the array when the next write data arrives. A read of a pending address is served from that register, merged by lane.

The block has a clock-enable stall, three chip selects of mixed polarity, per-byte write enables, an output enable and a burst-advance input. Burst advance steps the two low address bits in linear or interleaved order. The bidirectional data bus is modelled as an input, an output and a driver enable.

Top module: `lt_sram`

## Requirements
- R1: While and after reset, `dq_oe_o` is low and every word of the array reads as zero.
- R2: A write command is a cycle with `cen_ni`=0, `adv_i`=0, all chips selected and `we_ni`=0. Its address and byte enables are taken on that edge, and `dq_i` is written on the next edge with `cen_ni`=0.
- R3: A read command (as in R2 but `we_ni`=1) with `oe_ni`=0 makes `dq_oe_o` high during the following cycle, with `dq_o` equal to the addressed word.
- R4: Reads and writes may follow each other in any order at one per cycle. A read always returns the most recently written data of its address, including data from the write just before it.
- R5: `bw_ni[k]`=0 enables byte lane k, bits [8k+7:8k]. Lanes whose enable is 1 keep their old contents. The enables are taken on the same edge as the address.
- R6: With `lin_burst_i`=1, each `adv_i`=1 cycle steps the low two address bits to (start+n) mod 4, where start is the command's low bits and n counts the advances.
- R7: With `lin_burst_i`=0, the low two address bits after n advances are start XOR (n mod 4).
- R8: During an `adv_i`=1 cycle, `addr_i`, the three chip selects and `we_ni` are ignored. The previous operation type, including deselect, continues. The byte enables are taken again for each beat.
- R9: An edge with `cen_ni`=1 changes no state: no command, no burst step and no write data capture. Outputs hold while `oe_ni` is unchanged.
- R10: The block is deselected by `sel0_ni`=1, `sel1_i`=0 or `sel2_ni`=1 on a command edge. The next cycle then has `dq_oe_o` low and writes nothing.
- R11: `oe_ni`=1 holds `dq_oe_o` low without affecting writes.
- R12: In the data cycle of a write, `dq_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| sel0_ni | input | 1 | Chip select, active low |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | 0 = write, 1 = read |
| adv_i | input | 1 | Burst advance |
| lin_burst_i | input | 1 | 1 = linear burst, 0 = interleaved |
| bw_ni | input | NB | Byte write enables, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Word address |
| dq_i | input | DW | Write data (bus in) |
| dq_o | output | DW | Read data (bus out), zero when not driven |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
A stale pending register or a missing bypass shows up as old data on `dq_o` in the cycle right after a read follows a write to the same word. A lost commit shows up later, when a third write displaces the pending word. A wrong burst counter drives the wrong word on the first advanced beat. A stall that leaks into state shows up on the first enabled cycle after it, as changed data or a changed drive enable. Deselect and write-data cycles that drive the bus show up at once on `dq_oe_o`.

// File: rtl/lt_sram_pkg.sv
package lt_sram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {
    BURST_ILV = 1'b0,
    BURST_LIN = 1'b1
  } burst_mode_e;

  function automatic logic [BURST_W-1:0] burst_low(input logic [BURST_W-1:0] start,
                                                   input logic [BURST_W-1:0] step,
                                                   input burst_mode_e mode);
    return (mode == BURST_LIN) ? start + step : start ^ step;
  endfunction
endpackage

// File: rtl/lt_sram_cmd.sv
module lt_sram_cmd
  import lt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          lin_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] bw_i,
  output logic          vld_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [NB-1:0] bw_o
);
  localparam int HW = AW - BURST_W;

  logic               vld_q, wr_q;
  logic [HW-1:0]      hi_q;
  logic [BURST_W-1:0] start_q, step_q, low_q, step_nxt;
  logic [NB-1:0]      bw_q;

  assign step_nxt = step_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      wr_q    <= 1'b0;
      hi_q    <= '0;
      start_q <= '0;
      step_q  <= '0;
      low_q   <= '0;
      bw_q    <= '0;
    end else if (en_i) begin
      bw_q <= bw_i;
      if (adv_i) begin
        step_q <= step_nxt;
        low_q  <= burst_low(start_q, step_nxt, burst_mode_e'(lin_i));
      end else begin
        vld_q   <= sel_i;
        wr_q    <= wr_i;
        hi_q    <= addr_i[AW-1:BURST_W];
        start_q <= addr_i[BURST_W-1:0];
        step_q  <= '0;
        low_q   <= addr_i[BURST_W-1:0];
      end
    end
  end

  assign vld_o  = vld_q;
  assign wr_o   = wr_q;
  assign addr_o = {hi_q, low_q};
  assign bw_o   = bw_q;
endmodule

// File: rtl/lt_sram_array.sv
module lt_sram_array #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW/LW-1:0] wbe_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NB    = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] wmask;

  for (genvar k = 0; k < NB; k++) begin : g_mask
    assign wmask[k*LW +: LW] = {LW{wbe_i[k]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= (mem_q[waddr_i] & ~wmask) | (wdata_i & wmask);
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lt_sram_wbuf.sv
module lt_sram_wbuf #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW/LW-1:0] bw_i,
  input  logic [DW-1:0]    data_i,
  output logic             cmt_o,
  output logic [AW-1:0]    cmt_addr_o,
  output logic [DW/LW-1:0] cmt_bw_o,
  output logic [DW-1:0]    cmt_data_o,
  output logic             pend_vld_o,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [DW-1:0]    arr_data_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int NB = DW / LW;

  logic          pend_vld_q;
  logic [AW-1:0] pend_addr_q;
  logic [NB-1:0] pend_bw_q;
  logic [DW-1:0] pend_data_q;
  logic          hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_bw_q   <= '0;
      pend_data_q <= '0;
    end else if (cap_i) begin
      pend_vld_q  <= 1'b1;
      pend_addr_q <= addr_i;
      pend_bw_q   <= bw_i;
      pend_data_q <= data_i;
    end
  end

  // older pending word drains into the array as the new one arrives
  assign cmt_o      = cap_i & pend_vld_q;
  assign cmt_addr_o = pend_addr_q;
  assign cmt_bw_o   = pend_bw_q;
  assign cmt_data_o = pend_data_q;
  assign pend_vld_o = pend_vld_q;

  assign hit = pend_vld_q && (pend_addr_q == rd_addr_i);

  for (genvar k = 0; k < NB; k++) begin : g_byp
    assign rd_data_o[k*LW +: LW] = (hit && pend_bw_q[k]) ? pend_data_q[k*LW +: LW]
                                                         : arr_data_i[k*LW +: LW];
  end
endmodule

// File: rtl/lt_sram.sv
module lt_sram #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int LW = 8,
  localparam int NB = DW / LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cen_ni,
  input  logic          sel0_ni,
  input  logic          sel1_i,
  input  logic          sel2_ni,
  input  logic          we_ni,
  input  logic          adv_i,
  input  logic          lin_burst_i,
  input  logic [NB-1:0] bw_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic          en, sel;
  logic          st_vld, st_wr;
  logic [AW-1:0] st_addr;
  logic [NB-1:0] st_bw;
  logic          cap, cmt, pend_vld;
  logic [AW-1:0] cmt_addr;
  logic [NB-1:0] cmt_bw;
  logic [DW-1:0] cmt_data, arr_data, rd_data;

  assign en  = ~cen_ni;
  assign sel = ~sel0_ni & sel1_i & ~sel2_ni;

  lt_sram_cmd #(.AW(AW), .NB(NB)) cmd_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .adv_i  (adv_i),
    .sel_i  (sel),
    .wr_i   (~we_ni),
    .lin_i  (lin_burst_i),
    .addr_i (addr_i),
    .bw_i   (~bw_ni),
    .vld_o  (st_vld),
    .wr_o   (st_wr),
    .addr_o (st_addr),
    .bw_o   (st_bw)
  );

  // the edge that ends a write's stage cycle is its data edge
  assign cap = en & st_vld & st_wr;

  lt_sram_wbuf #(.AW(AW), .DW(DW), .LW(LW)) wbuf_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .addr_i     (st_addr),
    .bw_i       (st_bw),
    .data_i     (dq_i),
    .cmt_o      (cmt),
    .cmt_addr_o (cmt_addr),
    .cmt_bw_o   (cmt_bw),
    .cmt_data_o (cmt_data),
    .pend_vld_o (pend_vld),
    .rd_addr_i  (st_addr),
    .arr_data_i (arr_data),
    .rd_data_o  (rd_data)
  );

  lt_sram_array #(.AW(AW), .DW(DW), .LW(LW)) array_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmt),
    .waddr_i (cmt_addr),
    .wbe_i   (cmt_bw),
    .wdata_i (cmt_data),
    .raddr_i (st_addr),
    .rdata_o (arr_data)
  );

  assign dq_oe_o = st_vld & ~st_wr & ~oe_ni;
  assign dq_o    = dq_oe_o ? rd_data : '0;
endmodule

// File: rtl/lt_sram_chk.sv
module lt_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cen_ni,
  input logic          sel0_ni,
  input logic          sel1_i,
  input logic          sel2_ni,
  input logic          we_ni,
  input logic          adv_i,
  input logic          lin_burst_i,
  input logic          oe_ni,
  input logic          dq_oe_o,
  input logic          st_vld,
  input logic          st_wr,
  input logic [AW-1:0] st_addr,
  input logic          pend_vld
);
  logic cmd_edge, chip_on;
  assign cmd_edge = ~cen_ni & ~adv_i;
  assign chip_on  = ~sel0_ni & sel1_i & ~sel2_ni;

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_edge && chip_on && we_ni && !oe_ni) |=> (dq_oe_o || oe_ni)); // R3

  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_i && lin_burst_i) |=> (st_addr[1:0] == $past(st_addr[1:0]) + 2'd1)); // R6

  AST_ILV_BIT0_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_i && !lin_burst_i) |=> (st_addr[0] != $past(st_addr[0]))); // R7

  AST_ADV_KEEPS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_i) |=> ($stable(st_addr[AW-1:2]) && $stable(st_vld) && $stable(st_wr))); // R8

  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(st_addr) && $stable(st_vld) && $stable(st_wr) && $stable(pend_vld))); // R9

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_edge && !chip_on) |=> !dq_oe_o); // R10

  AST_WDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_edge && chip_on && !we_ni) |=> !dq_oe_o); // R12
endmodule

bind lt_sram lt_sram_chk #(.AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cen_ni      (cen_ni),
  .sel0_ni     (sel0_ni),
  .sel1_i      (sel1_i),
  .sel2_ni     (sel2_ni),
  .we_ni       (we_ni),
  .adv_i       (adv_i),
  .lin_burst_i (lin_burst_i),
  .oe_ni       (oe_ni),
  .dq_oe_o     (dq_oe_o),
  .st_vld      (st_vld),
  .st_wr       (st_wr),
  .st_addr     (st_addr),
  .pend_vld    (pend_vld)
);

// File: tb/lt_sram_tb_top.sv
`timescale 1ns/1ps
module lt_sram_tb_top;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int LW    = 8;
  localparam int NB    = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cen_n = 1'b0, sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
  logic          we_n = 1'b1, adv = 1'b0, lin = 1'b1, oe_n = 1'b0;
  logic [NB-1:0] bw_n = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #5 clk = ~clk;

  lt_sram #(.AW(AW), .DW(DW), .LW(LW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cen_ni (cen_n),
    .sel0_ni (sel0_n), .sel1_i (sel1), .sel2_ni (sel2_n),
    .we_ni (we_n), .adv_i (adv), .lin_burst_i (lin), .bw_ni (bw_n),
    .oe_ni (oe_n), .addr_i (addr), .dq_i (dq_in),
    .dq_o (dq_out), .dq_oe_o (dq_oe)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_vld = 0, m_wr = 0;
  int            m_addr = 0, m_start = 0, m_step = 0;
  logic [NB-1:0] m_bw = '0;

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      m_vld = 0; m_wr = 0; m_addr = 0; m_start = 0; m_step = 0; m_bw = '0;
    end else if (!cen_n) begin
      if (m_vld && m_wr)
        for (int k = 0; k < NB; k++)
          if (m_bw[k]) m_mem[m_addr][k*LW +: LW] = dq_in[k*LW +: LW];
      if (adv) begin
        int lo;
        m_step = (m_step + 1) % 4;
        lo = lin ? (m_start + m_step) % 4 : (m_start ^ m_step);
        m_addr = (m_addr & ~3) | lo;
      end else begin
        m_vld   = !sel0_n && sel1 && !sel2_n;
        m_wr    = !we_n;
        m_addr  = int'(addr);
        m_start = int'(addr) % 4;
        m_step  = 0;
      end
      m_bw = ~bw_n;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic          e_oe;
      logic [DW-1:0] e_dq;
      e_oe = m_vld && !m_wr && !oe_n;
      e_dq = e_oe ? m_mem[m_addr] : '0;
      n_chk++;
      if (dq_oe !== e_oe || dq_out !== e_dq) begin
        n_fail++;
        $display("FAIL %s t=%0t oe=%0b dq=%h expected oe=%0b dq=%h",
                 cur_req, $time, dq_oe, dq_out, e_oe, e_dq);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] d);
    adv = 0; we_n = 1; addr = AW'(a); dq_in = d; tick();
  endtask

  task automatic wr(input int a, input logic [NB-1:0] bwn, input logic [DW-1:0] d);
    adv = 0; we_n = 0; addr = AW'(a); bw_n = bwn; dq_in = d; tick();
  endtask

  task automatic beat(input logic [DW-1:0] d);
    adv = 1; dq_in = d; tick(); adv = 0;
  endtask

  task automatic idle(input logic [DW-1:0] d);
    adv = 0; we_n = 1; sel0_n = 1; dq_in = d; tick(); sel0_n = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s: got hang expected completion", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int a = 0; a < 4; a++) rd(a, '0);
    idle('0);

    // R2 / R4: write then read same word immediately
    cur_req = "R2";
    wr(5, '0, '0);
    cur_req = "R4";
    rd(5, 32'hA5A5_1234);
    rd(5, '0);
    wr(6, '0, '0);
    wr(7, '0, 32'h0606_0606);
    rd(6, 32'h0707_0707);
    rd(7, '0);
    wr(5, '0, '0);
    rd(6, 32'hBEEF_0005);
    rd(5, '0);

    // R3: plain reads of untouched and written words
    cur_req = "R3";
    rd(9, '0); rd(5, '0); rd(12, '0);
    idle('0);

    // R5: byte lane enables, lanes 0 and 2 enabled (bw_ni=1010)
    cur_req = "R5";
    wr(9, 4'b0000, '0);
    wr(9, 4'b1010, 32'hFFFF_FFFF);
    rd(9, 32'h1122_3344);
    rd(9, '0);
    wr(10, 4'b0111, '0);
    rd(10, 32'hAB00_0000);
    idle('0);

    // R6: linear burst from low bits 1
    cur_req = "R6";
    lin = 1;
    wr(13, '0, '0);
    beat(32'h0000_000D);
    beat(32'h0000_000E);
    beat(32'h0000_000F);
    rd(13, 32'h0000_000C);
    beat('0); beat('0); beat('0);
    beat('0);
    idle('0);

    // R7: interleaved burst from low bits 1 (1,0,3,2)
    cur_req = "R7";
    lin = 0;
    wr(17, '0, '0);
    beat(32'h1111_0011);
    beat(32'h1111_0010);
    beat(32'h1111_0013);
    rd(18, 32'h1111_0012);
    beat('0); beat('0); beat('0);
    rd(17, '0);
    beat('0); beat('0); beat('0);
    lin = 1;
    idle('0);

    // R8: inputs ignored during advance
    cur_req = "R8";
    rd(20, '0);
    we_n = 0; sel0_n = 1; sel1 = 0; addr = 6'd40; adv = 1; dq_in = '0; tick();
    tick();
    sel0_n = 0; sel1 = 1; adv = 0;
    idle('0);
    beat('0); beat('0);
    idle('0);

    // R9: stall inside a write and inside a read
    cur_req = "R9";
    wr(30, '0, '0);
    cen_n = 1; dq_in = 32'hDEAD_DEAD; addr = 6'd3; we_n = 1; tick(); tick();
    cen_n = 0;
    rd(30, 32'h3030_3030);
    cen_n = 1; addr = 6'd0; tick(); tick();
    cen_n = 0;
    rd(31, '0);
    idle('0);

    // R10: each chip select alone deselects; deselected write has no effect
    cur_req = "R10";
    sel0_n = 1; rd(5, '0); sel0_n = 0;
    sel1 = 0;   rd(5, '0); sel1 = 1;
    sel2_n = 1; wr(5, '0, '0); sel2_n = 0;
    rd(5, 32'h5555_5555);
    rd(5, '0);

    // R11: output enable gates drive only
    cur_req = "R11";
    oe_n = 1;
    rd(5, '0);
    wr(33, '0, '0);
    rd(33, 32'h3333_0033);
    oe_n = 0;
    rd(33, '0);
    idle('0);

    // R12: write data cycles between reads never drive
    cur_req = "R12";
    rd(7, '0); wr(8, '0, '0); rd(7, 32'h8888_8888); wr(8, 4'b1110, '0); rd(8, 32'h0000_00EE);
    idle('0);

    // R4: random mix of all operations
    cur_req = "R4";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 8);
      oe_n = ($urandom % 6) == 0;
      case (r)
        0, 1: rd(int'($urandom % DEPTH), $urandom);
        2, 3: wr(int'($urandom % DEPTH), NB'($urandom), $urandom);
        4:    beat($urandom);
        5:    idle($urandom);
        6:    begin cen_n = 1; dq_in = $urandom; tick(); cen_n = 0; end
        default: begin
          sel2_n = 1; we_n = 0; adv = 0; addr = AW'($urandom); dq_in = $urandom; tick();
          sel2_n = 0;
        end
      endcase
    end
    oe_n = 0;
    idle('0);
    idle('0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule